// File: doc/BRIEF.md
# Four-Port Cell Transmit Ingress

This block sits on the physical-layer side of a byte-wide cell transmit bus and is shared by four ports. The sending device watches each port's cell-available line. It marks the first byte of a cell with a start-of-cell strobe, and it raises the enable of one port for every clock on which it puts a byte on the bus. The block checks odd parity on every byte. It aligns cells on the start-of-cell strobe and writes each 53-byte cell into a small buffer that belongs to the port.

The sender may drop enable part way through a cell. Transfer then pauses and picks up again where it left off. A new start-of-cell that arrives before the current cell is complete discards the partial cell and starts over. A downstream consumer picks a port and drains complete cells from its buffer one byte per clock. A cell is offered to the consumer only after its last byte has been stored.

Top module: `cell_tx_ingress`

## Requirements
- R1: `tx_clav[p]` is high exactly when port p's buffer holds fewer than DEPTH (default 2) cells, counting committed cells plus a cell that is partly received. After reset all four lines are high. After DEPTH complete cells that have not been drained, the line is low.
- R2: A byte is taken only on a clock where the port's enable is high. A low enable in the middle of a cell stalls the cell without aborting it, and the stored cell equals the 53 bytes sent while enable was high, in order.
- R3: A byte that has enable high but no start-of-cell while the port is not inside a cell is ignored. It stores nothing, leaves `tx_clav` and `drain_ready` unchanged, and sets no flag even if its parity is wrong.
- R4: Parity is odd: XOR of the 8 data bits and `tx_par` must be 1. A stored byte that fails this sets that port's sticky `parity_err` bit, and the byte is still stored unchanged.
- R5: A start-of-cell during an incomplete cell discards the partial cell, starts a new cell with the current byte, and sets that port's sticky `frame_err` bit.
- R6: `drain_ready` for a port rises on the clock edge that stores the 53rd byte of a cell and is low before that edge.
- R7: When several enables are high on one clock, only the lowest-numbered port takes the byte.
- R8: Draining presents the bytes of the oldest cell in order, one per clock with `drain_req` high, with `drain_first` high on byte 0. After the 53rd byte the cell's space is freed and `tx_clav` returns high.
- R9: A start-of-cell to a port that already holds DEPTH complete cells is dropped together with the rest of that cell, and the stored cells are unchanged.
- R10: After reset, `drain_ready` is low for every port and `parity_err` and `frame_err` are zero. Both error vectors never clear until reset.
- R11: When the last byte of a cell is stored on the same clock that the last byte of another cell of the same port is drained, the occupancy stays consistent: afterwards one cell is ready and `tx_clav` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for bus and drain side |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Transmit byte from the sending device |
| tx_par | input | 1 | Odd parity bit for `tx_data` |
| tx_soc | input | 1 | Start-of-cell strobe, high with byte 0 |
| tx_en | input | 4 | Per-port transfer enable, active high |
| tx_clav | output | 4 | Per-port room for one whole cell |
| drain_port | input | 2 | Port selected by the consumer |
| drain_req | input | 1 | Consume the presented byte this clock |
| drain_ready | output | 1 | Selected port holds a complete cell |
| drain_data | output | 8 | Current byte of the selected port's oldest cell |
| drain_first | output | 1 | Presented byte is byte 0 of its cell |
| parity_err | output | 4 | Sticky per-port parity failure |
| frame_err | output | 4 | Sticky per-port early start-of-cell |

## Verification
Two functions can fall on the same clock: the commit of a cell's 53rd written byte and the release of a drained cell in the same port. The bench provokes this by running a write of one cell and a drain of an older cell in lockstep, so that both final bytes meet on one edge. It then judges the result from `tx_clav`, from `drain_ready`, and from the content of the cell that remains. A second overlap, a parity fault landing on a byte that is also part of a paused transfer, is judged from the sticky flag together with the drained content.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
    localparam int OCTET_W = 8;
    localparam int ATM_CELL_OCTETS = 53;

    typedef logic [OCTET_W-1:0] octet_t;

    // odd parity holds when the nine bits together carry an odd count of ones
    function automatic logic odd_parity_ok(input octet_t d, input logic p);
        return ^{d, p};
    endfunction
endpackage

// File: rtl/tx_bus_front.sv
module tx_bus_front
    import cell_tx_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS-1:0] tx_en,
    input  octet_t               tx_data,
    input  logic                 tx_par,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 par_ok
);
    // lowest-numbered active enable takes the bus
    always_comb begin
        grant = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (tx_en[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign par_ok = odd_parity_ok(tx_data, tx_par);
endmodule

// File: rtl/tx_cell_buffer.sv
module tx_cell_buffer
    import cell_tx_pkg::*;
#(
    parameter int CELL_BYTES = ATM_CELL_OCTETS,
    parameter int DEPTH      = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   wr_soc,
    input  octet_t wr_data,
    input  logic   wr_par_ok,
    input  logic   rd_en,
    output logic   clav,
    output logic   rd_ready,
    output octet_t rd_data,
    output logic   rd_first,
    output logic   par_err,
    output logic   frame_err
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(CELL_BYTES + 1);
    localparam int OCC_W  = $clog2(DEPTH + 1);
    localparam int WORDS  = DEPTH * CELL_BYTES;
    localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] wr_slot;
        logic [CNT_W-1:0]  wr_cnt;
        logic [SLOT_W-1:0] rd_slot;
        logic [CNT_W-1:0]  rd_cnt;
        logic [OCC_W-1:0]  full_cells;
        logic              par_err;
        logic              frame_err;
    } buf_state_t;

    buf_state_t s_d, s_q;

    octet_t            mem [WORDS];
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic              commit;
    logic              freed;

    function automatic logic [ADDR_W-1:0] addr_of(input logic [SLOT_W-1:0] slot,
                                                  input logic [CNT_W-1:0]  cnt);
        return ADDR_W'(int'(slot) * CELL_BYTES + int'(cnt));
    endfunction

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] slot);
        return (slot == SLOT_W'(DEPTH - 1)) ? '0 : slot + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        commit    = 1'b0;
        freed     = 1'b0;

        // write side: alignment on start-of-cell, stall on low enable
        if (wr_en) begin
            if (wr_soc) begin
                if (s_q.active) begin
                    s_d.frame_err = 1'b1;
                    s_d.wr_cnt    = CNT_W'(1);
                    mem_we        = 1'b1;
                    mem_waddr     = addr_of(s_q.wr_slot, '0);
                end else if (s_q.full_cells < OCC_W'(DEPTH)) begin
                    s_d.active = 1'b1;
                    s_d.wr_cnt = CNT_W'(1);
                    mem_we     = 1'b1;
                    mem_waddr  = addr_of(s_q.wr_slot, '0);
                end
            end else if (s_q.active) begin
                mem_we    = 1'b1;
                mem_waddr = addr_of(s_q.wr_slot, s_q.wr_cnt);
                if (s_q.wr_cnt == CNT_W'(CELL_BYTES - 1)) begin
                    s_d.active  = 1'b0;
                    s_d.wr_cnt  = '0;
                    s_d.wr_slot = next_slot(s_q.wr_slot);
                    commit      = 1'b1;
                end else begin
                    s_d.wr_cnt = s_q.wr_cnt + 1'b1;
                end
            end
            if (mem_we && !wr_par_ok) begin
                s_d.par_err = 1'b1;
            end
        end

        // drain side: one byte per request while a whole cell is held
        if (rd_en && (s_q.full_cells != '0)) begin
            if (s_q.rd_cnt == CNT_W'(CELL_BYTES - 1)) begin
                s_d.rd_cnt  = '0;
                s_d.rd_slot = next_slot(s_q.rd_slot);
                freed       = 1'b1;
            end else begin
                s_d.rd_cnt = s_q.rd_cnt + 1'b1;
            end
        end

        s_d.full_cells = s_q.full_cells + OCC_W'(commit) - OCC_W'(freed);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[mem_waddr] <= wr_data;
        end
    end

    assign clav      = ({1'b0, s_q.full_cells} + (OCC_W+1)'(s_q.active)) < (OCC_W+1)'(DEPTH);
    assign rd_ready  = (s_q.full_cells != '0);
    assign rd_data   = mem[addr_of(s_q.rd_slot, s_q.rd_cnt)];
    assign rd_first  = (s_q.rd_cnt == '0);
    assign par_err   = s_q.par_err;
    assign frame_err = s_q.frame_err;
endmodule

// File: rtl/cell_tx_ingress.sv
module cell_tx_ingress
    import cell_tx_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int CELL_BYTES = ATM_CELL_OCTETS,
    parameter int DEPTH      = 2,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           tx_data,
    input  logic                 tx_par,
    input  logic                 tx_soc,
    input  logic [NUM_PORTS-1:0] tx_en,
    output logic [NUM_PORTS-1:0] tx_clav,
    input  logic [PORT_W-1:0]    drain_port,
    input  logic                 drain_req,
    output logic                 drain_ready,
    output logic [7:0]           drain_data,
    output logic                 drain_first,
    output logic [NUM_PORTS-1:0] parity_err,
    output logic [NUM_PORTS-1:0] frame_err
);
    logic [NUM_PORTS-1:0] grant;
    logic                 par_ok;
    logic [NUM_PORTS-1:0] ready_v;
    logic [NUM_PORTS-1:0] first_v;
    octet_t               data_v [NUM_PORTS];

    tx_bus_front #(.NUM_PORTS(NUM_PORTS)) u_front (
        .tx_en   (tx_en),
        .tx_data (tx_data),
        .tx_par  (tx_par),
        .grant   (grant),
        .par_ok  (par_ok)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tx_cell_buffer #(.CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (grant[p]),
            .wr_soc    (tx_soc),
            .wr_data   (tx_data),
            .wr_par_ok (par_ok),
            .rd_en     (drain_req && (drain_port == PORT_W'(p))),
            .clav      (tx_clav[p]),
            .rd_ready  (ready_v[p]),
            .rd_data   (data_v[p]),
            .rd_first  (first_v[p]),
            .par_err   (parity_err[p]),
            .frame_err (frame_err[p])
        );
    end

    always_comb begin
        drain_ready = 1'b0;
        drain_data  = '0;
        drain_first = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (drain_port == PORT_W'(p)) begin
                drain_ready = ready_v[p];
                drain_data  = data_v[p];
                drain_first = first_v[p];
            end
        end
    end
endmodule

// File: rtl/cell_tx_ingress_chk.sv
module cell_tx_ingress_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           tx_data,
    input logic                 tx_par,
    input logic                 tx_soc,
    input logic [NUM_PORTS-1:0] tx_en,
    input logic [NUM_PORTS-1:0] tx_clav,
    input logic [PORT_W-1:0]    drain_port,
    input logic                 drain_req,
    input logic                 drain_ready,
    input logic [NUM_PORTS-1:0] parity_err,
    input logic [NUM_PORTS-1:0] frame_err
);
    // R4
    parity_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(parity_err & ~$past(parity_err))) |-> ($past(|tx_en) && !$past(^{tx_data, tx_par})));

    // R5
    frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(frame_err & ~$past(frame_err))) |-> $past(tx_soc && (|tx_en)));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(parity_err | frame_err) & ~(parity_err | frame_err)) == '0));

    // R8
    clav_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_clav & ~$past(tx_clav))) |-> $past(drain_req && drain_ready));

    // R1
    clav_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~tx_clav & $past(tx_clav))) |-> $past(tx_soc && (|tx_en)));

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_ready && !$past(drain_ready) && (drain_port == $past(drain_port)))
        |-> $past(|tx_en));
endmodule

bind cell_tx_ingress cell_tx_ingress_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_data     (tx_data),
    .tx_par      (tx_par),
    .tx_soc      (tx_soc),
    .tx_en       (tx_en),
    .tx_clav     (tx_clav),
    .drain_port  (drain_port),
    .drain_req   (drain_req),
    .drain_ready (drain_ready),
    .parity_err  (parity_err),
    .frame_err   (frame_err)
);

// File: tb/test_cell_tx_ingress.sv
module test_cell_tx_ingress;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int CELL = 53;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    tx_data = '0;
    logic          tx_par = 1'b0;
    logic          tx_soc = 1'b0;
    logic [NP-1:0] tx_en = '0;
    logic [NP-1:0] tx_clav;
    logic [1:0]    drain_port = '0;
    logic          drain_req = 1'b0;
    logic          drain_ready;
    logic [7:0]    drain_data;
    logic          drain_first;
    logic [NP-1:0] parity_err;
    logic [NP-1:0] frame_err;

    int n_checks = 0;
    int n_fail   = 0;

    cell_tx_ingress i_cell_tx_ingress (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_data     (tx_data),
        .tx_par      (tx_par),
        .tx_soc      (tx_soc),
        .tx_en       (tx_en),
        .tx_clav     (tx_clav),
        .drain_port  (drain_port),
        .drain_req   (drain_req),
        .drain_ready (drain_ready),
        .drain_data  (drain_data),
        .drain_first (drain_first),
        .parity_err  (parity_err),
        .frame_err   (frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input int port, input int seed, input int i);
        return 8'(seed * 29 + i * 7 + port * 61 + i * i);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sends n bytes; gap>0 inserts an idle clock before every gap-th byte; bad_idx gets wrong parity
    task automatic send_cell(input logic [NP-1:0] en, input int port, input int seed, input int gap,
                             input int bad_idx, input int n, input bit soc_first, input bit chk_vis);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk);
                tx_en  = '0;
                tx_soc = 1'b0;
            end
            @(negedge clk);
            if (chk_vis && i == CELL - 1)
                chk(drain_ready == 1'b0, "R6 not ready before last byte", int'(drain_ready), 0);
            tx_en   = en;
            tx_soc  = soc_first && (i == 0);
            tx_data = pat(port, seed, i);
            tx_par  = (i == bad_idx) ? ^tx_data : ~^tx_data;
        end
        @(negedge clk);
        tx_en  = '0;
        tx_soc = 1'b0;
    endtask

    task automatic drain_cell(input int port, input int seed, input string req);
        drain_port = 2'(port);
        drain_req  = 1'b1;
        for (int i = 0; i < CELL; i++) begin
            #1;
            chk(drain_ready == 1'b1, req, int'(drain_ready), 1);
            chk(drain_first == (i == 0), "R8 first marker", int'(drain_first), int'(i == 0));
            chk(drain_data == pat(port, seed, i), req, int'(drain_data), int'(pat(port, seed, i)));
            @(negedge clk);
        end
        drain_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(tx_clav == 4'hF, "R1 clav after reset", int'(tx_clav), 15);
        chk(parity_err == 4'h0, "R10 parity_err reset", int'(parity_err), 0);
        chk(frame_err == 4'h0, "R10 frame_err reset", int'(frame_err), 0);
        for (int p = 0; p < NP; p++) begin
            drain_port = 2'(p);
            #1;
            chk(drain_ready == 1'b0, "R10 ready low after reset", int'(drain_ready), 0);
        end

        // R2 R1 R6 R9 R8 sweep over all ports with different pause patterns
        for (int p = 0; p < NP; p++) begin
            drain_port = 2'(p);
            send_cell(4'(1 << p), p, 10 + p, p, -1, CELL, 1'b1, 1'b1);
            #1;
            chk(drain_ready == 1'b1, "R6 ready after last byte", int'(drain_ready), 1);
            chk(tx_clav[p] == 1'b1, "R1 clav with one cell", int'(tx_clav[p]), 1);
            send_cell(4'(1 << p), p, 20 + p, 3 - p, -1, CELL, 1'b1, 1'b0);
            #1;
            chk(tx_clav[p] == 1'b0, "R1 clav low when full", int'(tx_clav[p]), 0);
            send_cell(4'(1 << p), p, 30 + p, 0, -1, CELL, 1'b1, 1'b0);
            @(negedge clk);
            drain_cell(p, 10 + p, "R2 R9 first cell content");
            drain_cell(p, 20 + p, "R9 second cell content");
            #1;
            chk(drain_ready == 1'b0, "R9 dropped cell not stored", int'(drain_ready), 0);
            chk(tx_clav[p] == 1'b1, "R8 clav back after drain", int'(tx_clav[p]), 1);
        end

        // R3 stray bytes without start-of-cell, with bad parity
        drain_port = 2'd0;
        send_cell(4'b0001, 0, 5, 0, 3, 10, 1'b0, 1'b0);
        #1;
        chk(tx_clav == 4'hF, "R3 clav unchanged", int'(tx_clav), 15);
        chk(drain_ready == 1'b0, "R3 nothing stored", int'(drain_ready), 0);
        chk(parity_err == 4'h0, "R3 no flag for ignored byte", int'(parity_err), 0);

        // R4 parity fault on byte 10 of port 1, paused transfer
        send_cell(4'b0010, 1, 77, 4, 10, CELL, 1'b1, 1'b0);
        #1;
        chk(parity_err == 4'b0010, "R4 sticky parity flag", int'(parity_err), 2);
        chk(frame_err == 4'h0, "R4 no frame flag", int'(frame_err), 0);
        drain_cell(1, 77, "R4 byte still stored");
        #1;
        chk(parity_err == 4'b0010, "R10 parity flag sticky", int'(parity_err), 2);

        // R5 early start-of-cell on port 2
        drain_port = 2'd2;
        send_cell(4'b0100, 2, 40, 0, -1, 20, 1'b1, 1'b0);
        #1;
        chk(drain_ready == 1'b0, "R5 partial not visible", int'(drain_ready), 0);
        send_cell(4'b0100, 2, 41, 0, -1, CELL, 1'b1, 1'b0);
        #1;
        chk(frame_err == 4'b0100, "R5 sticky frame flag", int'(frame_err), 4);
        drain_cell(2, 41, "R5 restarted cell content");
        #1;
        chk(drain_ready == 1'b0, "R5 only one cell kept", int'(drain_ready), 0);

        // R7 two enables high: port 2 wins over port 3
        send_cell(4'b1100, 2, 50, 0, -1, CELL, 1'b1, 1'b0);
        drain_port = 2'd3;
        #1;
        chk(drain_ready == 1'b0, "R7 higher port took nothing", int'(drain_ready), 0);
        chk(tx_clav[3] == 1'b1, "R7 higher port clav", int'(tx_clav[3]), 1);
        @(negedge clk);
        drain_cell(2, 50, "R7 lowest port content");

        // R11 commit and release on the same edge in port 0
        send_cell(4'b0001, 0, 60, 0, -1, CELL, 1'b1, 1'b0);
        drain_port = 2'd0;
        drain_req  = 1'b1;
        for (int i = 0; i < CELL; i++) begin
            tx_en   = 4'b0001;
            tx_soc  = (i == 0);
            tx_data = pat(0, 61, i);
            tx_par  = ~^tx_data;
            #1;
            chk(drain_data == pat(0, 60, i), "R11 drain during write", int'(drain_data), int'(pat(0, 60, i)));
            @(negedge clk);
        end
        tx_en     = '0;
        tx_soc    = 1'b0;
        drain_req = 1'b0;
        #1;
        chk(drain_ready == 1'b1, "R11 one cell ready", int'(drain_ready), 1);
        chk(tx_clav[0] == 1'b1, "R11 clav after overlap", int'(tx_clav[0]), 1);
        @(negedge clk);
        drain_cell(0, 61, "R11 new cell content");
        #1;
        chk(drain_ready == 1'b0, "R11 empty after drain", int'(drain_ready), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule